// File: doc/BRIEF.md
# ADC Serial Result Readout Shifter

This block is the readout half of a converter's serial port. Each conversion-done strobe hands it a 16-bit unsigned result and the 3-bit number of the channel that produced it. The pair is kept in a holding register until the host opens a frame by pulling the active-low chip-select down. On that falling edge the pair moves into the output register, and the word is then shifted out on the serial data line, most significant bit first. The line moves on one bit per falling edge of the serial clock, so the host can sample it on the rising edge.

An optional tag appends the three channel bits after the LSB. Past the data and tag, the line carries zeros until chip-select rises. The data line is driven only inside a frame, and a separate enable output marks when it is driven. The first frame after a reset sends ones in every bit position, so the host can tell that a reset took place.

The block runs on one system clock. Chip-select, the serial clock and the strobe are taken to be synchronous to it already. Every output responds one system-clock edge after the input change that causes it.

Top module: `adc_readout_shifter`

## Requirements
- R1: While reset is asserted and afterwards while chip-select stays high, `sdo_oe` is 0 and `sdo_out` is 0.
- R2: `sdo_oe` becomes 1 one clock edge after `cs_n` is sampled low and returns to 0 one clock edge after `cs_n` is sampled high.
- R3: In the first frame after any reset, `sdo_out` is 1 in every bit position of the frame, including positions past the data and tag bits.
- R4: After one complete chip-select low period, the marker is cleared and the next frame carries latched result data.
- R5: Bit position k of a frame (k = 0 at chip-select fall, incremented by each sampled serial-clock fall) for k = 0..15 carries result bit 15-k. It is valid one clock edge after the serial-clock fall and holds until the next fall.
- R6: The output register loads from the holding register only on the falling edge of chip-select. A strobe during a frame does not change that frame's bits. The following frame reads the newer result.
- R7: `tag_en` is sampled at chip-select fall. When it is 1, positions 16, 17 and 18 carry channel bits 2, 1 and 0 (channel 5 gives 1,0,1). When it is 0, those positions carry 0.
- R8: Every position after the last data or tag bit carries 0 until chip-select rises.
- R9: A frame ended after fewer than 16 serial clocks has sent only leading MSBs. The next frame starts again at bit 15 of its own result.
- R10: A conversion-done strobe in the same clock cycle as the chip-select fall is forwarded, so that frame reads the new result and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc | input | 1 | Conversion-done strobe, one cycle |
| eoc_data | input | 16 | Conversion result, straight binary |
| eoc_chan | input | 3 | Channel that produced the result |
| tag_en | input | 1 | Append channel bits after the LSB |
| cs_n | input | 1 | Active-low frame/chip-select |
| sclk | input | 1 | Serial shift clock |
| sdo_out | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
Chip-select and serial-clock inputs pass through one sampling register, so every output change appears one system-clock edge after the input that caused it. The bench drives inputs and samples outputs on the falling system-clock edge, one period after the change. The first bit is due one edge after chip-select goes low. Each later bit is due one edge after the serial-clock low level is driven, and the enable drop is due one edge after chip-select is raised. Expected bits come from the requirement formula for position k, given the result, channel, tag setting and marker state.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the ADC serial readout shifter.
package adc_rd_pkg;
    // Source selected for the bit currently presented on the data line
    typedef enum logic [1:0] {
        SRC_DATA = 2'd0,
        SRC_TAG  = 2'd1,
        SRC_FILL = 2'd2,
        SRC_MARK = 2'd3
    } bit_src_t;
endpackage

// File: rtl/line_sampler.sv
`timescale 1ns/1ps
// line_sampler: registers a vector of control lines for one cycle, so that
// edges can be found by comparing the live value with the stored one.
// Assumes the lines are already synchronous to clk.
module line_sampler #(
    parameter int WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    // Hold the previous-cycle value of every line
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
    end
endmodule

// File: rtl/result_latch.sv
`timescale 1ns/1ps
// result_latch: holds the latest conversion result and channel, and moves
// them into the output register when a frame opens. A strobe in the same
// cycle as the load is forwarded straight to the output register.
module result_latch #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc,
    input  logic [DATA_W-1:0] eoc_data,
    input  logic [TAG_W-1:0]  eoc_chan,
    input  logic              load,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_chan
);
    logic [DATA_W-1:0] hold_data;
    logic [TAG_W-1:0]  hold_chan;

    // Capture every conversion-done strobe into the holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_chan <= '0;
        end else if (eoc) begin
            hold_data <= eoc_data;
            hold_chan <= eoc_chan;
        end
    end

    // Load the output register at frame start, preferring a same-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_chan <= '0;
        end else if (load) begin
            out_data <= eoc ? eoc_data : hold_data;
            out_chan <= eoc ? eoc_chan : hold_chan;
        end
    end
endmodule

// File: rtl/bit_sequencer.sv
`timescale 1ns/1ps
// bit_sequencer: counts bit positions inside a frame and selects the bit
// on the data line: result MSB first, then optional channel tag, then zeros.
// In a marker frame every position is one. The count saturates past the tag.
module bit_sequencer
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift,
    input  logic              tag_en,
    input  logic              marker,
    input  logic [DATA_W-1:0] data_i,
    input  logic [TAG_W-1:0]  chan_i,
    output logic              bit_out
);
    localparam int LAST  = DATA_W + TAG_W;
    localparam int CNT_W = $clog2(LAST + 1);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(LAST);

    logic [CNT_W-1:0]  cnt;
    logic              tag_q;
    logic              ones_q;
    bit_src_t          src;
    logic [DATA_W-1:0] data_sh;
    logic [TAG_W-1:0]  chan_sh;

    // Position counter and per-frame options; frame start wins over a shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tag_q  <= 1'b0;
            ones_q <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            tag_q  <= tag_en;
            ones_q <= marker;
        end else if (shift && cnt != TAG_END) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Choose where the current bit comes from
    always_comb begin
        if (ones_q)                         src = SRC_MARK;
        else if (cnt < DATA_END)            src = SRC_DATA;
        else if (tag_q && cnt < TAG_END)    src = SRC_TAG;
        else                                src = SRC_FILL;
    end

    // Align the wanted bit to the top of each field
    always_comb begin
        data_sh = data_i << cnt;
        chan_sh = chan_i << (cnt - DATA_END);
    end

    // Drive the selected bit
    always_comb begin
        case (src)
            SRC_DATA: bit_out = data_sh[DATA_W-1];
            SRC_TAG:  bit_out = chan_sh[TAG_W-1];
            SRC_MARK: bit_out = 1'b1;
            default:  bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_readout_shifter.sv
`timescale 1ns/1ps
// adc_readout_shifter: serial readout of conversion results. Latches the
// latest result at chip-select fall, shifts it out on serial-clock falls,
// adds an optional channel tag, fills with zeros, and sends all ones in the
// first frame after reset. cs_n and sclk are assumed synchronous to clk.
module adc_readout_shifter #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc,
    input  logic [DATA_W-1:0] eoc_data,
    input  logic [TAG_W-1:0]  eoc_chan,
    input  logic              tag_en,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              sdo_out,
    output logic              sdo_oe
);
    logic [1:0]        lines_q;
    logic              cs_q, sclk_q;
    logic              cs_fall, cs_rise, sclk_fall;
    logic              marker;
    logic [DATA_W-1:0] word;
    logic [TAG_W-1:0]  chan;
    logic              seq_bit;

    line_sampler #(.WIDTH(2), .RST_VAL(2'b10)) u_lines (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sclk}), .q(lines_q)
    );

    // Decode control-line edges from the sampled and live values
    always_comb begin
        cs_q      = lines_q[1];
        sclk_q    = lines_q[0];
        cs_fall   = cs_q && !cs_n;
        cs_rise   = !cs_q && cs_n;
        sclk_fall = sclk_q && !sclk && !cs_q && !cs_n;
    end

    // Reset marker: set by reset, cleared when a frame closes
    always_ff @(posedge clk) begin
        if (!rst_n)       marker <= 1'b1;
        else if (cs_rise) marker <= 1'b0;
    end

    result_latch #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .eoc_data(eoc_data),
        .eoc_chan(eoc_chan), .load(cs_fall), .out_data(word), .out_chan(chan)
    );

    bit_sequencer #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(cs_fall), .shift(sclk_fall),
        .tag_en(tag_en), .marker(marker), .data_i(word), .chan_i(chan),
        .bit_out(seq_bit)
    );

    // Drive the line only inside a frame
    always_comb begin
        sdo_oe  = !cs_q;
        sdo_out = sdo_oe && seq_bit;
    end
endmodule

// File: rtl/adc_readout_chk.sv
`timescale 1ns/1ps
// adc_readout_chk: port-level properties of the readout shifter, bound to
// every instance of the top module.
module adc_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo_out,
    input logic sdo_oe
);
    logic seen_frame;

    // Remember whether a frame has closed since reset
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_frame <= 1'b0;
        else if (sdo_oe && cs_n)   seen_frame <= 1'b1;
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo_out);

    // R2
    oe_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> $rose(sdo_oe));

    // R2
    oe_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    // R3
    marker_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_frame && sdo_oe) |-> sdo_out);

    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !($past(sclk) && !sclk)) |=> $stable(sdo_out));
endmodule

bind adc_readout_shifter adc_readout_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdo_out(sdo_out), .sdo_oe(sdo_oe)
);

// File: tb/adc_readout_shifter_test.sv
`timescale 1ns/1ps
module adc_readout_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc = 1'b0;
    logic [15:0] eoc_data = '0;
    logic [2:0]  eoc_chan = '0;
    logic        tag_en = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdo_out, sdo_oe;
    int total = 0;
    int bad = 0;
    bit done = 0;

    adc_readout_shifter uut (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .eoc_data(eoc_data),
        .eoc_chan(eoc_chan), .tag_en(tag_en), .cs_n(cs_n), .sclk(sclk),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe)
    );

    always #4 clk = ~clk;

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(bit ones, logic [15:0] d, logic [2:0] c,
                                     bit tg, int k);
        if (ones)            return 1'b1;
        if (k < 16)          return d[15-k];
        if (tg && k < 19)    return c[18-k];
        return 1'b0;
    endfunction

    task automatic pulse_eoc(logic [15:0] d, logic [2:0] c);
        eoc = 1'b1; eoc_data = d; eoc_chan = c;
        tick();
        eoc = 1'b0;
    endtask

    task automatic start_frame(bit tg);
        tag_en = tg;
        cs_n = 1'b0;
        tick();
        check("R2", sdo_oe, 1'b1, "oe at frame start");
    endtask

    task automatic bits(string req, int from, int upto, bit ones,
                        logic [15:0] d, logic [2:0] c, bit tg);
        for (int k = from; k < upto; k++) begin
            check(req, sdo_out, exp_bit(ones, d, c, tg, k), $sformatf("bit %0d", k));
            sclk = 1'b1; tick();
            sclk = 1'b0; tick();
        end
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        tick();
        check("R2", sdo_oe, 1'b0, "oe after frame");
        check("R1", sdo_out, 1'b0, "idle line");
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        check("R1", sdo_oe, 1'b0, "oe in reset");
        check("R1", sdo_out, 1'b0, "sdo in reset");
        rst_n = 1'b1;
        tick(2);
        check("R1", sdo_oe, 1'b0, "oe after reset");
    endtask

    initial begin
        logic [15:0] d, e;
        logic [2:0]  c;
        tick();
        do_reset();

        // R3: marker frame regardless of a pending result
        pulse_eoc(16'h1234, 3'd6);
        start_frame(1'b1);
        bits("R3", 0, 24, 1'b1, 16'h1234, 3'd6, 1'b1);
        end_frame();

        // R4: next frame gives the held result
        start_frame(1'b0);
        bits("R4", 0, 20, 1'b0, 16'h1234, 3'd6, 1'b0);
        end_frame();

        // R5 R7 R8: sweep channels, tag on and off, varied data
        for (int i = 0; i < 16; i++) begin
            d = 16'hA5C3 ^ 16'(i * 16'h1111);
            c = 3'(i);
            pulse_eoc(d, c);
            start_frame(i[0]);
            bits(i[0] ? "R7" : "R8", 0, 22, 1'b0, d, c, i[0]);
            end_frame();
        end

        // R5: walking one across the result, with boundary codes
        for (int b = 0; b < 18; b++) begin
            d = (b == 16) ? 16'h0000 : (b == 17) ? 16'hFFFF : 16'(1 << b);
            pulse_eoc(d, 3'd2);
            start_frame(1'b0);
            bits("R5", 0, 17, 1'b0, d, 3'd2, 1'b0);
            end_frame();
        end

        // R6: strobe during a frame does not disturb it
        d = 16'hC0DE; e = 16'h3A71;
        pulse_eoc(d, 3'd1);
        start_frame(1'b1);
        bits("R6", 0, 7, 1'b0, d, 3'd1, 1'b1);
        pulse_eoc(e, 3'd4);
        bits("R6", 7, 20, 1'b0, d, 3'd1, 1'b1);
        end_frame();
        start_frame(1'b1);
        bits("R6", 0, 20, 1'b0, e, 3'd4, 1'b1);
        end_frame();

        // R9: short command frame then full frame from the MSB
        d = 16'h9F06;
        pulse_eoc(d, 3'd7);
        start_frame(1'b0);
        bits("R9", 0, 4, 1'b0, d, 3'd7, 1'b0);
        end_frame();
        start_frame(1'b1);
        bits("R9", 0, 20, 1'b0, d, 3'd7, 1'b1);
        end_frame();

        // R10: strobe coincident with chip-select fall
        tag_en = 1'b1;
        eoc = 1'b1; eoc_data = 16'h5EA7; eoc_chan = 3'd5;
        cs_n = 1'b0;
        tick();
        eoc = 1'b0;
        bits("R10", 0, 20, 1'b0, 16'h5EA7, 3'd5, 1'b1);
        end_frame();

        // R3: a later reset brings the marker back, then R4 data again
        do_reset();
        pulse_eoc(16'h0F0F, 3'd3);
        start_frame(1'b0);
        bits("R3", 0, 20, 1'b1, 16'h0F0F, 3'd3, 1'b0);
        end_frame();
        start_frame(1'b1);
        bits("R4", 0, 20, 1'b0, 16'h0F0F, 3'd3, 1'b1);
        end_frame();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule